// File: doc/BRIEF.md
# Two-Stage Serial Baud Tick Generator

This block produces the two timing strobes that a serial transmitter and receiver need: a bit-sample tick used by a receiver to oversample the line, and a baud tick that paces the transmitted bit stream. Both strobes are derived from the system clock through two dividers in series. The first divider is 16 bits wide and turns a step enable into sample ticks. The second divider is 8 bits wide and counts sample ticks to make baud ticks. The sample rate is the selected clock over the sample divider. The baud rate is the selected clock over the product of the sample divider and (baud divider + 1).

A select input chooses the step enable. When the select is low, the enable is high on every system clock. When it is high, a free-running prescaler makes the enable high on one system clock in eight. No derived clock is created; everything runs on `clk_i`.

Both divider values are written through simple write ports and can be read back. A baud divider write below 4 is dropped. A sample divider of zero stops all ticks. A new divider value is picked up only when its counter next reloads, so a period that is already running always finishes at its old length.

Top module: `baud_tick_gen`

## Requirements
- R1: With the select low and a sample divider N in 1..65535, `sample_tick_o` pulses on exactly one clock in every N clocks.
- R2: While the sample divider in use is 0, neither tick output pulses. The generator restarts after a nonzero value is written.
- R3: `baud_tick_o` pulses in the same cycle as every (D+1)-th sample tick, where D is the baud divider, and never in a cycle without a sample tick.
- R4: A baud divider write with a value of 4..255 is stored. A write with a value of 0..3 is ignored, and the previous value stays on `baud_div_o`.
- R5: After reset, `samp_div_o` reads 0x028B and `baud_div_o` reads 0x0F. The first sample tick comes 0x028B step enables after reset is released, and the first baud tick comes on the 16th sample tick.
- R6: With the select high, the step enable is high on one system clock in eight. The prescaler runs freely from reset, so the enable is high when its count reaches 7. The sample tick period then becomes 8·N clocks.
- R7: A divider write takes effect at the next reload of its counter. The period that is already running completes at its old length, with its tick.
- R8: Each tick is a single-cycle pulse registered in the `clk_i` domain. `baud_tick_o` is never high in two consecutive cycles.
- R9: A written divider value appears on its readback output in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prescale_sel_i | input | 1 | 0: step on every clock; 1: step on every eighth clock |
| samp_div_we_i | input | 1 | Write strobe for the sample divider |
| samp_div_wdata_i | input | 16 | Sample divider write value |
| baud_div_we_i | input | 1 | Write strobe for the baud divider |
| baud_div_wdata_i | input | 8 | Baud divider write value |
| samp_div_o | output | 16 | Sample divider readback |
| baud_div_o | output | 8 | Baud divider readback |
| sample_tick_o | output | 1 | One-cycle bit-sample strobe |
| baud_tick_o | output | 1 | One-cycle baud strobe |

## Verification
The divider chain is tried with its reset values. It is also tried with small sample dividers, including 1, where the sample tick is high on every cycle and only the baud divider spaces the baud ticks. The largest accepted baud divider is tried as well. These cases separate off-by-one errors in each stage and show whether the two stages are counted separately. A divider write while a period is running shows whether the old period completes or is cut short. A zero sample divider followed by a restart exercises the gated state and the way out of it. Baud writes of 2 and 3, set against writes of 4 and 255, locate the acceptance floor exactly. Prescaled runs show that the clock enable reaches both stages.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned SAMP_W      = 16;
  localparam int unsigned BAUD_W      = 8;
  localparam int unsigned PRE_RATIO   = 8;
  localparam int unsigned BAUD_MIN    = 4;
  localparam logic [SAMP_W-1:0] SAMP_RST = 16'h028B;
  localparam logic [BAUD_W-1:0] BAUD_RST = 8'h0F;
endpackage

// File: rtl/bg_prescaler.sv
// Free-running clock-enable source: every clock, or one in RATIO clocks.
module bg_prescaler #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic step_o
);
  generate
    if (RATIO <= 1) begin : g_bypass
      assign step_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign step_o = !sel_i || wrap;
    end
  endgenerate
endmodule

// File: rtl/bg_div_regs.sv
// Divider value registers with write filtering on the baud divider.
module bg_div_regs
  import baud_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_we_i,
  input  logic [SAMP_W-1:0] samp_wdata_i,
  input  logic              baud_we_i,
  input  logic [BAUD_W-1:0] baud_wdata_i,
  output logic [SAMP_W-1:0] samp_q_o,
  output logic [BAUD_W-1:0] baud_q_o
);
  localparam logic [BAUD_W-1:0] FLOOR = BAUD_W'(BAUD_MIN);

  logic [SAMP_W-1:0] samp_q, samp_d;
  logic [BAUD_W-1:0] baud_q, baud_d;
  logic              baud_ok;

  assign baud_ok = (baud_wdata_i >= FLOOR);

  always_comb begin
    samp_d = samp_q;
    baud_d = baud_q;
    if (samp_we_i)            samp_d = samp_wdata_i;
    if (baud_we_i && baud_ok) baud_d = baud_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= SAMP_RST;
      baud_q <= BAUD_RST;
    end else begin
      samp_q <= samp_d;
      baud_q <= baud_d;
    end
  end

  assign samp_q_o = samp_q;
  assign baud_q_o = baud_q;
endmodule

// File: rtl/bg_reload_cnt.sv
// Down counter that hits at zero and then reloads. The reload value is
// sampled only at the hit, so a write never cuts a running period short.
// load_ok_i low at reload parks the counter (no further hits) until a
// later step finds it high.
module bg_reload_cnt #(
  parameter int unsigned  W       = 16,
  parameter logic [W-1:0] CNT_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] load_val_i,
  input  logic         load_ok_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (step_i) begin
      if (at_zero) begin
        cnt_d = load_ok_i ? load_val_i : '0;
        run_d = load_ok_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_RST;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign hit_o = step_i && at_zero && run_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prescale_sel_i,
  input  logic              samp_div_we_i,
  input  logic [SAMP_W-1:0] samp_div_wdata_i,
  input  logic              baud_div_we_i,
  input  logic [BAUD_W-1:0] baud_div_wdata_i,
  output logic [SAMP_W-1:0] samp_div_o,
  output logic [BAUD_W-1:0] baud_div_o,
  output logic              sample_tick_o,
  output logic              baud_tick_o
);
  localparam logic [SAMP_W-1:0] SAMP_CNT_RST = SAMP_RST - 1'b1;

  logic              step;
  logic [SAMP_W-1:0] samp_q;
  logic [BAUD_W-1:0] baud_q;
  logic              samp_nz;
  logic [SAMP_W-1:0] samp_load;
  logic              samp_hit, baud_hit;
  logic              stick_q, stick_d, btick_q, btick_d;

  bg_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (prescale_sel_i),
    .step_o (step)
  );

  bg_div_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .samp_we_i    (samp_div_we_i),
    .samp_wdata_i (samp_div_wdata_i),
    .baud_we_i    (baud_div_we_i),
    .baud_wdata_i (baud_div_wdata_i),
    .samp_q_o     (samp_q),
    .baud_q_o     (baud_q)
  );

  // A zero sample divider parks the first stage; the second stage then
  // receives no steps and is idle as well.
  assign samp_nz   = (samp_q != '0);
  assign samp_load = samp_nz ? samp_q - 1'b1 : '0;

  bg_reload_cnt #(.W(SAMP_W), .CNT_RST(SAMP_CNT_RST)) u_samp_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .load_val_i (samp_load),
    .load_ok_i  (samp_nz),
    .hit_o      (samp_hit)
  );

  // Second stage: a period of (baud divider + 1) sample ticks.
  bg_reload_cnt #(.W(BAUD_W), .CNT_RST(BAUD_RST)) u_baud_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (samp_hit),
    .load_val_i (baud_q),
    .load_ok_i  (1'b1),
    .hit_o      (baud_hit)
  );

  always_comb begin
    stick_d = samp_hit;
    btick_d = baud_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stick_q <= 1'b0;
      btick_q <= 1'b0;
    end else begin
      stick_q <= stick_d;
      btick_q <= btick_d;
    end
  end

  assign sample_tick_o = stick_q;
  assign baud_tick_o   = btick_q;
  assign samp_div_o    = samp_q;
  assign baud_div_o    = baud_q;
endmodule

module baud_tick_gen_chk
  import baud_gen_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prescale_sel_i,
  input logic              baud_div_we_i,
  input logic [BAUD_W-1:0] baud_div_wdata_i,
  input logic [BAUD_W-1:0] baud_div_o,
  input logic              sample_tick_o,
  input logic              baud_tick_o
);
  // R3
  baud_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> sample_tick_o);

  // R4
  baud_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_div_o >= BAUD_W'(BAUD_MIN));

  // R4
  small_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud_div_we_i && (baud_div_wdata_i < BAUD_W'(BAUD_MIN))) |=> $stable(baud_div_o));

  // R8
  baud_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |=> !baud_tick_o);

  // R6
  prescaled_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_tick_o && $past(sample_tick_o)) |-> !($past(prescale_sel_i) && $past(prescale_sel_i, 2)));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (.*);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        prescale_sel_i;
  logic        samp_div_we_i;
  logic [15:0] samp_div_wdata_i;
  logic        baud_div_we_i;
  logic [7:0]  baud_div_wdata_i;
  logic [15:0] samp_div_o;
  logic [7:0]  baud_div_o;
  logic        sample_tick_o;
  logic        baud_tick_o;

  int    n_checks = 0;
  int    n_fails  = 0;
  string tag      = "R5";
  bit    done     = 0;

  baud_tick_gen u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: counts enables and ticks up to the period.
  int pre, s_cnt, s_per, b_cnt, b_per, sdiv, bdiv;
  bit e_st, e_bt, en;
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      pre = 0; s_cnt = 0; s_per = 'h28B; b_cnt = 0; b_per = 15;
      sdiv = 'h28B; bdiv = 15; e_st = 0; e_bt = 0;
    end else begin
      en  = !prescale_sel_i || (pre == 7);
      pre = (pre + 1) % 8;
      e_st = 0; e_bt = 0;
      if (en) begin
        if (s_per == 0) begin
          s_per = sdiv; s_cnt = 0;
        end else begin
          s_cnt++;
          if (s_cnt == s_per) begin e_st = 1; s_cnt = 0; s_per = sdiv; end
        end
      end
      if (e_st) begin
        b_cnt++;
        if (b_cnt == b_per + 1) begin e_bt = 1; b_cnt = 0; b_per = bdiv; end
      end
      if (samp_div_we_i) sdiv = samp_div_wdata_i;
      if (baud_div_we_i && baud_div_wdata_i >= 4) bdiv = baud_div_wdata_i;
    end
  end

  // Per-cycle comparison away from the active edge.
  bit prev_bt = 0;
  int tick_seen = 0;
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && !done) begin
      check(tag, "sample_tick", sample_tick_o, e_st);
      check(tag, "baud_tick", baud_tick_o, e_bt);
      check("R9", "samp_div readback", samp_div_o, sdiv);
      check("R4", "baud_div readback", baud_div_o, bdiv);
      if (prev_bt && baud_tick_o) check("R8", "baud tick width", 2, 1);
      prev_bt = baud_tick_o;
      tick_seen += sample_tick_o + baud_tick_o;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_samp(int v);
    @(negedge clk_i);
    samp_div_we_i = 1; samp_div_wdata_i = 16'(v);
    @(negedge clk_i);
    samp_div_we_i = 0;
  endtask

  task automatic wr_baud(int v);
    @(negedge clk_i);
    baud_div_we_i = 1; baud_div_wdata_i = 8'(v);
    @(negedge clk_i);
    baud_div_we_i = 0;
  endtask

  initial begin
    rst_ni = 0; prescale_sel_i = 0;
    samp_div_we_i = 0; samp_div_wdata_i = '0;
    baud_div_we_i = 0; baud_div_wdata_i = '0;
    idle(4);
    rst_ni = 1;
    // R5: reset state at the ports
    check("R5", "reset samp_div", samp_div_o, 'h28B);
    check("R5", "reset baud_div", baud_div_o, 'h0F);
    check("R5", "reset ticks", sample_tick_o + baud_tick_o, 0);
    tag = "R5"; idle(11000);

    tag = "R1"; wr_samp(3); wr_baud(4); idle(200);
    tag = "R3"; wr_samp(1); idle(60);

    tag = "R4"; wr_baud(2); check("R4", "write 2 dropped", baud_div_o, 4);
    wr_baud(3); check("R4", "write 3 dropped", baud_div_o, 4);
    wr_baud(255); check("R4", "write 255 kept", baud_div_o, 255);
    idle(600);
    wr_baud(4); check("R4", "write 4 kept", baud_div_o, 4);
    idle(40);

    tag = "R2"; wr_samp(0); idle(20);
    tick_seen = 0; idle(100);
    check("R2", "ticks while gated", tick_seen, 0);
    tag = "R2"; wr_samp(5); idle(150);

    tag = "R6"; prescale_sel_i = 1; wr_samp(2); idle(500);
    tag = "R6"; wr_samp(1); idle(200);
    prescale_sel_i = 0;

    tag = "R7"; wr_samp(20); idle(7); wr_samp(3); idle(120);
    wr_baud(6); idle(5); wr_samp(7); idle(300);

    tag = "R1"; wr_samp(65535); idle(66000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule